// File: doc/BRIEF.md
# Synchronous Serial Receive Deserializer

This block turns a serial data line into parallel words. Each rising edge of the bit clock on which the frame-sync qualifier is high samples one bit into an assembly register. When the selected number of bits has been counted, the assembled word is copied into a read-only holding register and a receive-full flag is raised. The flag drives an interrupt output when the enable is set.

The host chooses three things. The word length is 8, 12, 16, 24 or 32 bit times. The bits arrive either most significant first or least significant first. The word is placed either left-justified at the top of the holding register or with its MSB at bit 15. Any holding-register bit that the word does not cover reads as zero. A host read strobe clears the full flag. If a second word lands before that read, an overrun flag is set and the newer word replaces the older one.

A rising edge of frame sync always starts a new word. While frame sync stays high, words follow one another with no gap bits between them.

Top module: `rxd_deser`

## Requirements
- R1: A bit is sampled only on an edge where `fsync` is 1. If `fsync` drops before a word is complete, the partial word is discarded and nothing is loaded into the holding register.
- R2: With `lsb_first` = 0 the first bit sampled is the word's MSB. With `lsb_first` = 1 the first bit sampled is the word's LSB.
- R3: `wl_sel` selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 24 and 4 gives 32. Codes 5 to 7 behave as 24. The holding register loads on the same edge that samples the last bit of the word.
- R4: For a 32-bit word, only the first 24 bits sampled are kept and the last 8 bit times are discarded. With MSB-first order the kept value is the top 24 bits of the word; with LSB-first order it is the low 24 bits.
- R5: With `align_lo` = 0, the word's MSB lands at bit 23. For 8-, 12- and 16-bit words, every bit below the word, including bits 7:0, is zero.
- R6: With `align_lo` = 1, the word's MSB lands at bit 15 and bits 23:16 are zero. For 24- and 32-bit words, the 8 least significant kept bits are dropped.
- R7: `rx_full` rises on a load and falls one cycle after a `rd_stb` pulse. If a load and a read fall on the same edge, the load wins. `rx_data` changes only on a load.
- R8: A load while `rx_full` is 1 and `rd_stb` is 0 sets `rx_ovr` and overwrites `rx_data`. A `rd_stb` with no load on the same edge clears `rx_ovr`.
- R9: `rx_irq` is 1 exactly when `rx_full` and `ie` are both 1.
- R10: The bit count restarts at every rising edge of `fsync`. While `fsync` stays high, each word begins on the edge after the previous word's last bit.
- R11: After reset, `rx_data`, `rx_full`, `rx_ovr` and `rx_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; everything samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync qualifier; bits are sampled while it is high |
| sdin | input | 1 | Serial data in |
| wl_sel | input | 3 | Word-length code |
| lsb_first | input | 1 | Bit-order select: 0 = MSB first, 1 = LSB first |
| align_lo | input | 1 | Alignment select: 0 = MSB at the top bit, 1 = MSB at bit 15 |
| ie | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Host read strobe for the holding register |
| rx_data | output | DATA_W | Holding register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench uses the default `DATA_W` of 24. With that width, every combination of the five word lengths, both bit orders and both alignments is small enough to sweep in full. Each combination is run with an all-ones word, a lone MSB and two scattered patterns, so the placement and zero-fill of every bit position is observed. The same configuration also reaches the 32-bit padding case, the reserved length codes, back-to-back words under a held frame sync, abandoned partial frames, and a load and a read landing on the same edge.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
   // Longest word the block counts, in bit times
   localparam int unsigned LEN_MAX = 32;
   // Width of the bit counter, wide enough to hold LEN_MAX
   localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);
   // Number of distinct word lengths
   localparam int unsigned NUM_WL  = 5;

   typedef enum logic [2:0] {
      WL_8  = 3'd0,
      WL_12 = 3'd1,
      WL_16 = 3'd2,
      WL_24 = 3'd3,
      WL_32 = 3'd4
   } wl_code_e;

   // Word length for a length code; unused codes fall back to 24
   function automatic int unsigned wl_len(input int unsigned code);
      case (code)
         0:       return 8;
         1:       return 12;
         2:       return 16;
         4:       return 32;
         default: return 24;
      endcase
   endfunction

   // Folds a raw length code onto the table index 0..NUM_WL-1
   function automatic logic [2:0] wl_index(input logic [2:0] code);
      return (code > WL_32) ? WL_24 : code;
   endfunction
endpackage

// File: rtl/rxd_bitcnt.sv
`timescale 1ns/1ps
module rxd_bitcnt
   import rxd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   input  logic [2:0]       wl_sel,
   output logic [CNT_W-1:0] bit_idx,
   output logic [CNT_W-1:0] word_len,
   output logic             word_first,
   output logic             word_end
);
   logic [CNT_W-1:0] cnt_q;
   logic             fsync_q;
   logic             fs_rise;

   assign word_len   = CNT_W'(wl_len(int'(wl_index(wl_sel))));
   assign fs_rise    = fsync & ~fsync_q;
   // A new frame always starts counting from bit zero
   assign bit_idx    = fs_rise ? '0 : cnt_q;
   assign word_first = fsync && (bit_idx == '0);
   assign word_end   = fsync && (bit_idx == (word_len - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fsync_q <= 1'b0;
      end else begin
         fsync_q <= fsync;
         if (!fsync || word_end) cnt_q <= '0;
         else                    cnt_q <= bit_idx + 1'b1;
      end
   end
endmodule

// File: rtl/rxd_assemble.sv
`timescale 1ns/1ps
module rxd_assemble
   import rxd_pkg::*;
#(
   parameter int unsigned DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              word_first,
   input  logic [CNT_W-1:0]  bit_idx,
   input  logic [CNT_W-1:0]  word_len,
   input  logic              lsb_first,
   input  logic              sdin,
   output logic [DATA_W-1:0] word_now
);
   localparam logic [CNT_W-1:0] KEEP_MAX = CNT_W'(DATA_W);

   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] sr_next;
   logic [CNT_W-1:0]  keep_len;
   logic [CNT_W-1:0]  pos;
   logic              keep_bit;

   // Lengths longer than the register keep only their first DATA_W bits
   assign keep_len = (word_len > KEEP_MAX) ? KEEP_MAX : word_len;
   assign keep_bit = bit_vld && (bit_idx < keep_len);
   // Right-justified bit position of the bit being sampled
   assign pos      = lsb_first ? bit_idx : (keep_len - 1'b1 - bit_idx);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign sr_next[i] = (keep_bit && (pos == CNT_W'(i))) ? sdin :
                          (word_first ? 1'b0 : sr_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (bit_vld) sr_q <= sr_next;
   end

   // The word including the bit being sampled, for the load on its last edge
   assign word_now = sr_next;
endmodule

// File: rtl/rxd_align.sv
`timescale 1ns/1ps
module rxd_align
   import rxd_pkg::*;
#(
   parameter int unsigned DATA_W = 24
) (
   input  logic [DATA_W-1:0] word,
   input  logic [2:0]        wl_sel,
   input  logic              align_lo,
   output logic [DATA_W-1:0] aligned
);
   // Field width when the top byte is left unused
   localparam int unsigned     LO_W    = DATA_W - 8;
   localparam logic [DATA_W-1:0] LO_MASK = {{8{1'b0}}, {LO_W{1'b1}}};

   logic [DATA_W-1:0] cand_hi [NUM_WL];
   logic [DATA_W-1:0] cand_lo [NUM_WL];
   logic [2:0]        sel;

   // One fixed shift per length, so no barrel shifter is needed
   for (genvar c = 0; c < NUM_WL; c++) begin : g_len
      localparam int unsigned LEN = wl_len(c);
      localparam int unsigned K   = (LEN > DATA_W) ? DATA_W : LEN;
      assign cand_hi[c] = word << (DATA_W - K);
      if (K <= LO_W) begin : g_up
         assign cand_lo[c] = (word << (LO_W - K)) & LO_MASK;
      end else begin : g_down
         assign cand_lo[c] = (word >> (K - LO_W)) & LO_MASK;
      end
   end

   assign sel     = wl_index(wl_sel);
   assign aligned = align_lo ? cand_lo[sel] : cand_hi[sel];
endmodule

// File: rtl/rxd_status.sv
`timescale 1ns/1ps
module rxd_status #(
   parameter int unsigned DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              rd_stb,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
         rx_ovr  <= 1'b0;
      end else if (load) begin
         rx_data <= din;
         rx_full <= 1'b1;
         // A read on the same edge acknowledges the old word
         rx_ovr  <= ~rd_stb & (rx_full | rx_ovr);
      end else if (rd_stb) begin
         rx_full <= 1'b0;
         rx_ovr  <= 1'b0;
      end
   end
endmodule

// File: rtl/rxd_deser.sv
`timescale 1ns/1ps
module rxd_deser
   import rxd_pkg::*;
#(
   parameter int unsigned DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              sdin,
   input  logic [2:0]        wl_sel,
   input  logic              lsb_first,
   input  logic              align_lo,
   input  logic              ie,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              rx_ovr,
   output logic              rx_irq
);
   if ((DATA_W < 16) || (DATA_W > LEN_MAX)) begin : g_bad_width
      $error("rxd_deser: DATA_W must lie between 16 and LEN_MAX");
   end

   logic [CNT_W-1:0]  bit_idx;
   logic [CNT_W-1:0]  word_len;
   logic              word_first;
   logic              word_end;
   logic [DATA_W-1:0] word_now;
   logic [DATA_W-1:0] word_aligned;

   rxd_bitcnt u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .wl_sel     (wl_sel),
      .bit_idx    (bit_idx),
      .word_len   (word_len),
      .word_first (word_first),
      .word_end   (word_end)
   );

   rxd_assemble #(.DATA_W(DATA_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_vld    (fsync),
      .word_first (word_first),
      .bit_idx    (bit_idx),
      .word_len   (word_len),
      .lsb_first  (lsb_first),
      .sdin       (sdin),
      .word_now   (word_now)
   );

   rxd_align #(.DATA_W(DATA_W)) u_align (
      .word     (word_now),
      .wl_sel   (wl_sel),
      .align_lo (align_lo),
      .aligned  (word_aligned)
   );

   rxd_status #(.DATA_W(DATA_W)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_end),
      .rd_stb  (rd_stb),
      .din     (word_aligned),
      .rx_data (rx_data),
      .rx_full (rx_full),
      .rx_ovr  (rx_ovr)
   );

   assign rx_irq = rx_full & ie;
endmodule

// File: rtl/rxd_deser_chk.sv
`timescale 1ns/1ps
module rxd_deser_chk #(
   parameter int unsigned DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fsync,
   input logic              rd_stb,
   input logic              ie,
   input logic              align_lo,
   input logic [2:0]        wl_sel,
   input logic              word_end,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic              rx_irq
);
   p_idle_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync |-> !word_end);

   p_load_sets_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_end |=> rx_full);

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !word_end) |=> (!rx_full && !rx_ovr));

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !word_end |=> $stable(rx_data));

   p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && rx_full && !rd_stb) |=> rx_ovr);

   p_irq_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ie && $past(word_end)) |-> rx_irq);

   p_top_byte_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_end && align_lo) |-> (rx_data[DATA_W-1 -: 8] == 8'h00));

   p_low_byte_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_end && !align_lo && (wl_sel <= 3'd2)) |-> (rx_data[7:0] == 8'h00));
endmodule

bind rxd_deser rxd_deser_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fsync    (fsync),
   .rd_stb   (rd_stb),
   .ie       (ie),
   .align_lo (align_lo),
   .wl_sel   (wl_sel),
   .word_end (word_end),
   .rx_data  (rx_data),
   .rx_full  (rx_full),
   .rx_ovr   (rx_ovr),
   .rx_irq   (rx_irq)
);

// File: tb/rxd_deser_tb.sv
`timescale 1ns/1ps
module rxd_deser_tb;
   localparam int DATA_W = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsync = 1'b0;
   logic sdin = 1'b0;
   logic [2:0] wl_sel = 3'd0;
   logic lsb_first = 1'b0;
   logic align_lo = 1'b0;
   logic ie = 1'b0;
   logic rd_stb = 1'b0;
   logic [DATA_W-1:0] rx_data;
   logic rx_full, rx_ovr, rx_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rxd_deser #(.DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin),
      .wl_sel(wl_sel), .lsb_first(lsb_first), .align_lo(align_lo),
      .ie(ie), .rd_stb(rd_stb),
      .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int len_of(input int code);
      case (code)
         0: return 8;
         1: return 12;
         2: return 16;
         4: return 32;
         default: return 24;
      endcase
   endfunction

   // Expected holding-register value, computed from R2..R6
   function automatic logic [31:0] expect_word(input logic [31:0] w, input int n,
                                                input bit lsbf, input bit alo);
      int k;
      logic [31:0] kept;
      logic [31:0] r;
      k = (n > 24) ? 24 : n;
      if (n == 32) kept = lsbf ? (w & 32'h00FF_FFFF) : (w >> 8);
      else         kept = w;
      if (!alo)         r = kept << (24 - k);
      else if (k <= 16) r = kept << (16 - k);
      else              r = kept >> (k - 16);
      if (alo) r = r & 32'h0000_FFFF;
      return r & 32'h00FF_FFFF;
   endfunction

   function automatic logic [31:0] mask_n(input logic [31:0] w, input int n);
      if (n >= 32) return w;
      return w & ((32'd1 << n) - 32'd1);
   endfunction

   task automatic drive_bits(input logic [31:0] w, input int n, input int cnt,
                             input bit lsbf, input bit rd_last);
      for (int j = 0; j < cnt; j++) begin
         @(negedge clk);
         fsync  = 1'b1;
         sdin   = lsbf ? w[j] : w[n-1-j];
         rd_stb = rd_last && (j == cnt - 1);
      end
   endtask

   task automatic end_frame();
      @(negedge clk);
      fsync  = 1'b0;
      rd_stb = 1'b0;
      sdin   = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] w;
      logic [31:0] hold;
      int n;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 data", 32'(rx_data), 32'h0);
      chk("R11 full", 32'(rx_full), 32'h0);
      chk("R11 ovr", 32'(rx_ovr), 32'h0);
      chk("R11 irq", 32'(rx_irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5 R6 R7 R9: full sweep of length, order and alignment
      for (int code = 0; code < 5; code++) begin
         for (int lb = 0; lb < 2; lb++) begin
            for (int al = 0; al < 2; al++) begin
               for (int p = 0; p < 4; p++) begin
                  n = len_of(code);
                  case (p)
                     0: w = 32'hFFFF_FFFF;
                     1: w = 32'd1 << (n - 1);
                     2: w = 32'hA5C3_1E96 ^ (32'(code) << 4);
                     default: w = 32'((code * 97 + lb * 31 + al * 7 + 3)) * 32'h9E37_79B1;
                  endcase
                  w = mask_n(w, n);
                  wl_sel    = 3'(code);
                  lsb_first = lb[0];
                  align_lo  = al[0];
                  ie        = p[0];
                  drive_bits(w, n, n, lb[0], 1'b0);
                  end_frame();
                  chk(n == 32 ? "R4 padded word" : (al != 0 ? "R6 low-aligned word" : "R5 top-aligned word"),
                      32'(rx_data), expect_word(w, n, lb[0], al[0]));
                  chk("R3 full after last bit", 32'(rx_full), 32'h1);
                  chk("R9 irq", 32'(rx_irq), 32'(p[0]));
                  chk("R8 no overrun", 32'(rx_ovr), 32'h0);
                  do_read();
                  chk("R7 read clears full", 32'(rx_full), 32'h0);
               end
            end
         end
      end

      // R2 R3: reserved length code acts as 24
      wl_sel = 3'd6; lsb_first = 1'b1; align_lo = 1'b0; ie = 1'b1;
      w = 32'h00C0_FFEE;
      drive_bits(w, 24, 24, 1'b1, 1'b0);
      end_frame();
      chk("R3 reserved code", 32'(rx_data), expect_word(w, 24, 1'b1, 1'b0));
      do_read();

      // R10 R8: back-to-back words under held frame sync
      wl_sel = 3'd0; lsb_first = 1'b0; align_lo = 1'b0;
      drive_bits(32'h3C, 8, 8, 1'b0, 1'b0);
      drive_bits(32'hC5, 8, 8, 1'b0, 1'b0);
      end_frame();
      chk("R10 second word", 32'(rx_data), 32'hC5_0000);
      chk("R8 overrun set", 32'(rx_ovr), 32'h1);
      chk("R8 full", 32'(rx_full), 32'h1);
      do_read();
      chk("R8 overrun cleared", 32'(rx_ovr), 32'h0);

      // R7 R8: load and read on the same edge
      drive_bits(32'h11, 8, 8, 1'b0, 1'b0);
      end_frame();
      drive_bits(32'h96, 8, 8, 1'b0, 1'b1);
      end_frame();
      chk("R7 load wins over read", 32'(rx_full), 32'h1);
      chk("R8 no overrun with read", 32'(rx_ovr), 32'h0);
      chk("R7 newest data", 32'(rx_data), 32'h96_0000);
      do_read();

      // R1 R10: abandoned partial word, then fresh frame
      drive_bits(32'hFF, 8, 5, 1'b0, 1'b0);
      end_frame();
      chk("R1 partial not loaded", 32'(rx_full), 32'h0);
      chk("R1 data kept", 32'(rx_data), 32'h96_0000);
      drive_bits(32'h5A, 8, 8, 1'b0, 1'b0);
      end_frame();
      chk("R10 restart on frame", 32'(rx_data), 32'h5A_0000);
      do_read();
      hold = 32'(rx_data);

      // R1: line activity with frame sync low
      for (int j = 0; j < 30; j++) begin
         @(negedge clk);
         sdin = j[0];
      end
      @(negedge clk);
      chk("R1 idle no load", 32'(rx_full), 32'h0);
      chk("R1 idle data", 32'(rx_data), hold);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule